// File: doc/BRIEF.md
# Out-of-Frame Safety SPI Target

This block is a 32-bit SPI target in which the answer to a request travels in the next chip-select frame, not in the frame that carried the request. A system clock oversamples the serial clock, the active-low chip select and the command input, so all logic is in one clock domain. Each frame is checked for length, command CRC and, when shared chip-select addressing is enabled, the 2-bit target address. An accepted command is held as a pending request, and the response word is built when chip select falls at the start of the next frame.

Bit 7 of the received target address chooses the response layout. A cleared bit gives a sensor-data answer, which carries a 16-bit sample and a 2-bit status. A set bit gives a register answer, which carries an 18-bit register value. The surrounding logic supplies these values on parallel inputs. It can use the `pend_ta` output to choose which register value to present. The serial output is a data/enable pair that a pad cell turns into a tri-state pin. The enable stays low for a whole frame whenever the previous frame was rejected. The interface is a fixed-rate serial link with nothing that could stall it, so the block has no valid/ready handshake. All of its pins are plain control and data pins.

Top module: `oof_spi_target`

## Requirements
- R1: Frames use clock mode 0. The target samples the command on rising serial-clock edges, shifts the response out on falling edges, and sends the most significant bit first. The first response bit is valid before the first rising edge after chip select falls.
- R2: A command accepted in frame N is answered in frame N+1. `pend_ta` changes only when chip select rises, and then it takes the target address of the accepted command (bits 31..22).
- R3: The CRC uses the polynomial x^3+x+1 with seed 101b. It is computed over bits 31..3 with three zero bits appended, and the result goes in bits 2..0. A command is accepted only when its field matches. Word 0x00000003 is accepted and word 0x00000000 is rejected.
- R4: A frame with any number of rising clock edges other than 32 is rejected.
- R5: When `common_addr_en` is 1, a command is rejected unless bits 31..30 equal `slave_addr`. When `common_addr_en` is 0, those bits are not compared.
- R6: If bit 7 of the accepted address is 0, the response holds: 1 in bit 31, status bit 1 in bit 20, `sens_data` in bits 19..4, and status bit 0 in bit 3. All four status codes pass through unchanged: 00 valid, 01 error or no data, 11 initialising with data, 10 user-defined with valid data.
- R7: If bit 7 of the accepted address is 1, the response holds 0 in bit 31 and `reg_data` in bits 20..3.
- R8: Response bits 30..29 carry `slave_addr`. Response bits 28..21 echo bits 7..0 of the accepted target address.
- R9: Response bits 2..0 hold the CRC of response bits 31..3, computed with the R3 rule.
- R10: After reset, and after any rejected frame, `spi_miso_oe` stays low for the whole next frame, and `spi_miso` is 0 whenever the enable is low.
- R11: `spi_miso_oe` is low within a few system clocks after chip select rises.
- R12: The response inputs are sampled once, when chip select falls. Changing them during the frame does not change the bits that are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Command data from the controller |
| spi_miso | output | 1 | Response data toward the pad |
| spi_miso_oe | output | 1 | Output enable for the response pad |
| slave_addr | input | 2 | Programmed target address |
| common_addr_en | input | 1 | Enables address matching for a shared chip select |
| sens_data | input | 16 | Sensor sample for sensor-data responses |
| sens_status | input | 2 | Sensor status code |
| reg_data | input | 18 | Register value for register responses |
| pend_ta | output | 10 | Target address of the last accepted command |

## Verification
Assertions check on every cycle that the output enable falls after chip select rises and rises only when a response is loaded. They also check that the output is quiet while the enable is low, that the pending address changes only at the end of a frame, and that the bit counter stays bounded. The bench scenarios are the only way to show the out-of-frame pairing of request and answer, the exact layout of both response formats, and the CRC values. The same holds for rejection of short, long, corrupted or misaddressed frames, and for sampling the inputs at chip-select fall rather than during the frame.

// File: rtl/oof_pkg.sv
package oof_pkg;
  localparam int FRAME_BITS = 32;
  localparam int CRC_W      = 3;
  localparam int BODY_W     = FRAME_BITS - CRC_W;
  localparam int TA_W       = 10;
  localparam int ADDR_W     = 2;
  localparam int DATA_W     = 16;
  localparam int REG_W      = 18;
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);
  localparam int KIND_BIT   = 7;
  localparam logic [CRC_W-1:0] CRC_SEED = 3'b101;
  localparam logic [CRC_W-1:0] CRC_TAPS = 3'b011;

  typedef enum logic {RESP_SENSOR = 1'b0, RESP_REG = 1'b1} resp_kind_t;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] r, input logic b);
    logic [CRC_W-1:0] n;
    n = {r[CRC_W-2:0], b};
    if (r[CRC_W-1]) n = n ^ CRC_TAPS;
    return n;
  endfunction

  function automatic logic [CRC_W-1:0] crc_of(input logic [BODY_W-1:0] body);
    logic [CRC_W-1:0] r;
    r = CRC_SEED;
    for (int i = BODY_W - 1; i >= 0; i--) r = crc_step(r, body[i]);
    for (int j = 0; j < CRC_W; j++) r = crc_step(r, 1'b0);
    return r;
  endfunction
endpackage

// File: rtl/oof_pin_sync.sv
module oof_pin_sync #(
  parameter int N = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] level,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  generate
    for (genvar p = 0; p < N; p++) begin : g_pin
      logic [STAGES:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {(STAGES+1){RST_VAL[p]}};
        else        chain <= {chain[STAGES-1:0], din[p]};
      end
      assign level[p] = chain[STAGES-1];
      assign rise[p]  = chain[STAGES-1] & ~chain[STAGES];
      assign fall[p]  = ~chain[STAGES-1] & chain[STAGES];
    end
  endgenerate
endmodule

// File: rtl/oof_rx_frame.sv
module oof_rx_frame
  import oof_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_low,
  input  logic              cs_rise,
  input  logic              sck_rise,
  input  logic              mosi_s,
  input  logic              common_en,
  input  logic [ADDR_W-1:0] slave_addr,
  output logic              frame_done,
  output logic              frame_ok,
  output logic [TA_W-1:0]   frame_ta
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] OVER = CNT_W'(FRAME_BITS + 1);

  logic [FRAME_BITS-1:0] sh;
  logic [CRC_W-1:0]      crc;
  logic [CNT_W-1:0]      cnt;
  logic                  addr_match;
  logic                  len_ok;
  logic                  crc_ok;

  assign addr_match = !common_en || (sh[FRAME_BITS-1 -: ADDR_W] == slave_addr);
  assign len_ok     = (cnt == FULL);
  assign crc_ok     = (crc == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; crc <= CRC_SEED; cnt <= '0;
      frame_done <= 1'b0; frame_ok <= 1'b0; frame_ta <= '0;
    end else begin
      frame_done <= 1'b0;
      if (cs_rise) begin
        frame_done <= 1'b1;
        frame_ok   <= len_ok && crc_ok && addr_match;
        frame_ta   <= sh[FRAME_BITS-1 -: TA_W];
        cnt        <= '0;
        crc        <= CRC_SEED;
      end else if (cs_low && sck_rise) begin
        sh  <= {sh[FRAME_BITS-2:0], mosi_s};
        crc <= crc_step(crc, mosi_s);
        if (cnt != OVER) cnt <= cnt + 1'b1;
      end else if (!cs_low) begin
        cnt <= '0;
        crc <= CRC_SEED;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= OVER); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done); // R2
endmodule

// File: rtl/oof_resp_build.sv
module oof_resp_build
  import oof_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_done,
  input  logic                  frame_ok,
  input  logic [TA_W-1:0]       frame_ta,
  input  logic                  cs_fall,
  input  logic [ADDR_W-1:0]     slave_addr,
  input  logic [DATA_W-1:0]     sens_data,
  input  logic [1:0]            sens_status,
  input  logic [REG_W-1:0]      reg_data,
  output logic                  load,
  output logic                  load_drive,
  output logic [FRAME_BITS-1:0] load_word,
  output logic [TA_W-1:0]       pend_ta
);
  logic                pend_valid;
  resp_kind_t          kind;
  logic [BODY_W-1:0]   body;

  assign kind = resp_kind_t'(pend_ta[KIND_BIT]);

  always_comb begin
    if (kind == RESP_SENSOR)
      body = {1'b1, slave_addr, pend_ta[KIND_BIT:0], sens_status[1], sens_data, sens_status[0]};
    else
      body = {1'b0, slave_addr, pend_ta[KIND_BIT:0], reg_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0; pend_ta <= '0;
      load <= 1'b0; load_drive <= 1'b0; load_word <= '0;
    end else begin
      load <= cs_fall;
      if (frame_done) begin
        pend_valid <= frame_ok;
        if (frame_ok) pend_ta <= frame_ta;
      end
      if (cs_fall) begin
        load_drive <= pend_valid;
        load_word  <= {body, crc_of(body)};
      end
    end
  end

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(pend_ta)); // R2
endmodule

// File: rtl/oof_tx_shift.sv
module oof_tx_shift
  import oof_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  load_drive,
  input  logic [FRAME_BITS-1:0] load_word,
  input  logic                  sck_fall,
  input  logic                  cs_rise,
  output logic                  miso,
  output logic                  miso_oe
);
  logic [FRAME_BITS-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; miso_oe <= 1'b0;
    end else if (load) begin
      sh <= load_word; miso_oe <= load_drive;
    end else if (cs_rise) begin
      miso_oe <= 1'b0;
    end else if (sck_fall && miso_oe) begin
      sh <= {sh[FRAME_BITS-2:0], 1'b0};
    end
  end

  assign miso = miso_oe & sh[FRAME_BITS-1];

  AST_OE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !miso_oe); // R11
  AST_OE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miso_oe) |-> $past(load)); // R10
  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !miso_oe |-> !miso); // R10
  AST_HOLD_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !sck_fall && !cs_rise) |=> $stable(miso)); // R1
endmodule

// File: rtl/oof_spi_target.sv
module oof_spi_target
  import oof_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic [ADDR_W-1:0] slave_addr,
  input  logic              common_addr_en,
  input  logic [DATA_W-1:0] sens_data,
  input  logic [1:0]        sens_status,
  input  logic [REG_W-1:0]  reg_data,
  output logic [TA_W-1:0]   pend_ta
);
  localparam int PIN_SCK = 0;
  localparam int PIN_CS  = 1;
  localparam int PIN_DI  = 2;

  logic [2:0] lvl, rise, fall;
  logic frame_done, frame_ok, load, load_drive;
  logic [TA_W-1:0] frame_ta;
  logic [FRAME_BITS-1:0] load_word;
  logic unused_edges;

  oof_pin_sync #(.N(3), .STAGES(2), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({spi_mosi, spi_cs_n, spi_sck}),
    .level(lvl), .rise(rise), .fall(fall));

  assign unused_edges = ^{rise[PIN_DI], fall[PIN_DI], lvl[PIN_SCK]};

  oof_rx_frame u_rx (
    .clk(clk), .rst_n(rst_n), .cs_low(!lvl[PIN_CS]), .cs_rise(rise[PIN_CS]),
    .sck_rise(rise[PIN_SCK]), .mosi_s(lvl[PIN_DI]), .common_en(common_addr_en),
    .slave_addr(slave_addr), .frame_done(frame_done), .frame_ok(frame_ok),
    .frame_ta(frame_ta));

  oof_resp_build u_build (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_ok(frame_ok),
    .frame_ta(frame_ta), .cs_fall(fall[PIN_CS]), .slave_addr(slave_addr),
    .sens_data(sens_data), .sens_status(sens_status), .reg_data(reg_data),
    .load(load), .load_drive(load_drive), .load_word(load_word), .pend_ta(pend_ta));

  oof_tx_shift u_tx (
    .clk(clk), .rst_n(rst_n), .load(load), .load_drive(load_drive),
    .load_word(load_word), .sck_fall(fall[PIN_SCK]), .cs_rise(rise[PIN_CS]),
    .miso(spi_miso), .miso_oe(spi_miso_oe));
endmodule

// File: tb/oof_spi_target_test.sv
module oof_spi_target_test;
  localparam int HP = 8;
  localparam int NV = 14;
  // entry: ta[23:14] nbits[13:8] badcrc[7] common[6] addr[5:4] status[3:2]
  localparam logic [23:0] VEC [NV] = '{
    {10'h000, 6'd32, 1'b0, 1'b1, 2'b00, 2'b00, 2'b00},
    {10'h005, 6'd32, 1'b0, 1'b1, 2'b00, 2'b01, 2'b00},
    {10'h0B6, 6'd32, 1'b0, 1'b1, 2'b00, 2'b11, 2'b00},
    {10'h012, 6'd32, 1'b0, 1'b1, 2'b00, 2'b10, 2'b00},
    {10'h100, 6'd32, 1'b0, 1'b1, 2'b00, 2'b00, 2'b00},
    {10'h003, 6'd32, 1'b0, 1'b1, 2'b00, 2'b01, 2'b00},
    {10'h044, 6'd31, 1'b0, 1'b1, 2'b00, 2'b00, 2'b00},
    {10'h045, 6'd33, 1'b0, 1'b1, 2'b00, 2'b00, 2'b00},
    {10'h046, 6'd32, 1'b1, 1'b1, 2'b00, 2'b00, 2'b00},
    {10'h1C7, 6'd32, 1'b0, 1'b0, 2'b10, 2'b11, 2'b00},
    {10'h27F, 6'd32, 1'b0, 1'b0, 2'b10, 2'b10, 2'b00},
    {10'h3FF, 6'd32, 1'b0, 1'b1, 2'b11, 2'b01, 2'b00},
    {10'h2AA, 6'd32, 1'b0, 1'b1, 2'b10, 2'b00, 2'b00},
    {10'h000, 6'd32, 1'b0, 1'b0, 2'b00, 2'b00, 2'b00}
  };

  logic clk = 0, rst_n = 0;
  logic sck = 0, cs_n = 1, mosi = 0;
  logic miso, miso_oe;
  logic [1:0] slave_addr = 0;
  logic common_en = 0;
  logic [15:0] sens_data = 0;
  logic [1:0] sens_status = 0;
  logic [17:0] reg_data = 0;
  logic [9:0] pend_ta;
  int checks = 0, fails = 0;
  logic [31:0] got;
  logic oe_all, oe_any, oe_after;

  always #4 clk = ~clk;

  oof_spi_target uut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .slave_addr(slave_addr),
    .common_addr_en(common_en), .sens_data(sens_data), .sens_status(sens_status),
    .reg_data(reg_data), .pend_ta(pend_ta));

  function automatic logic [2:0] tb_crc(input logic [28:0] m);
    logic [34:0] d;
    d = {3'b101, m, 3'b000};
    for (int i = 34; i >= 3; i--) if (d[i]) d[i -: 4] = d[i -: 4] ^ 4'b1011;
    return d[2:0];
  endfunction

  function automatic logic [31:0] exp_resp(input logic [9:0] ta, input logic [1:0] a,
      input logic [15:0] dat, input logic [1:0] st, input logic [17:0] rg);
    logic [28:0] b;
    if (!ta[7]) b = {1'b1, a, ta[7:0], st[1], dat, st[0]};
    else        b = {1'b0, a, ta[7:0], rg};
    return {b, tb_crc(b)};
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_frame(input logic [31:0] w, input int nbits,
      input logic chg, input logic [15:0] chg_data);
    got = 0; oe_all = 1; oe_any = 0;
    cs_n = 0;
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 32) ? w[31-i] : 1'b0;
      repeat (HP) @(negedge clk);
      if (i < 32) got[31-i] = miso;
      oe_all &= miso_oe; oe_any |= miso_oe;
      sck = 1;
      if (chg && i == 10) sens_data = chg_data;
      repeat (HP) @(negedge clk);
      sck = 0;
    end
    repeat (HP) @(negedge clk);
    cs_n = 1;
    repeat (HP) @(negedge clk);
    oe_after = miso_oe;
    repeat (2*HP) @(negedge clk);
  endtask

  function automatic logic [31:0] mk_cmd(input logic [9:0] ta, input logic [18:0] fill, input logic bad);
    logic [28:0] b;
    b = {ta, fill};
    return {b, tb_crc(b) ^ {2'b00, bad}};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic prev_ok;
    logic [9:0] prev_ta;
    string prev_why;
    repeat (5) @(negedge clk);
    check(miso_oe == 0 && miso == 0, "R10 reset", {30'd0, miso_oe, miso}, 32'd0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    prev_ok = 0; prev_ta = 0; prev_why = "R10 after reset";
    for (int k = 0; k < NV; k++) begin
      logic [9:0] ta; int nb; logic bad, ok;
      logic [31:0] exp;
      ta = VEC[k][23:14]; nb = int'(VEC[k][13:8]); bad = VEC[k][7];
      common_en = VEC[k][6]; slave_addr = VEC[k][5:4]; sens_status = VEC[k][3:2];
      sens_data = 16'h1357 * 16'(k + 1);
      reg_data = 18'h2A5A5 ^ 18'(k * 977);
      exp = exp_resp(prev_ta, slave_addr, sens_data, sens_status, reg_data);
      run_frame(mk_cmd(ta, 19'(k * 12345), bad), nb, 1'b0, 16'h0);
      if (prev_ok)
        check(oe_all && got == exp, "R1/R2/R6/R7/R8/R9 response", got, exp);
      else
        check(!oe_any, {prev_why, " hi-Z"}, {31'd0, oe_any}, 32'd0);
      check(!oe_after, "R11 oe after CS high", {31'd0, oe_after}, 32'd0);
      ok = (nb == 32) && !bad && (!common_en || ta[9:8] == slave_addr);
      if (nb != 32) prev_why = "R4 length";
      else if (bad) prev_why = "R3 crc";
      else if (!ok) prev_why = "R5 address";
      if (ok) check(pend_ta == ta, "R2 pend_ta", {22'd0, pend_ta}, {22'd0, ta});
      prev_ok = ok;
      if (ok) prev_ta = ta;
    end
    // R3: fixed CRC words
    common_en = 1; slave_addr = 2'b00; sens_status = 2'b00; sens_data = 16'hBEEF;
    run_frame(32'h00000003, 32, 1'b0, 16'h0);
    run_frame(32'h00000000, 32, 1'b0, 16'h0);
    check(oe_all && got == exp_resp(10'h000, 2'b00, 16'hBEEF, 2'b00, reg_data),
          "R3 word 00000003 accepted", got, exp_resp(10'h000, 2'b00, 16'hBEEF, 2'b00, reg_data));
    run_frame(mk_cmd(10'h001, 19'h0, 1'b0), 32, 1'b0, 16'h0);
    check(!oe_any, "R3 word 00000000 rejected", {31'd0, oe_any}, 32'd0);
    // R12: input change mid-frame ignored
    sens_data = 16'h4321; sens_status = 2'b11;
    run_frame(mk_cmd(10'h002, 19'h5, 1'b0), 32, 1'b1, 16'hFFFF);
    check(oe_all && got == exp_resp(10'h001, 2'b00, 16'h4321, 2'b11, reg_data),
          "R12 sampled at CS fall", got, exp_resp(10'h001, 2'b00, 16'h4321, 2'b11, reg_data));
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule